// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (SMBus)

This block is an SMBus target that keeps the configuration bank of a clock generator. A host reaches it with indexed block transfers. A write names a starting index, then a byte count, then that many data bytes. A read first sets the index with a short write. A repeated START with the read address follows, and the target answers with a byte count and then data starting at the chosen index. The index advances by one after every byte moved.

Both bus lines are sampled by the system clock through a synchronizer. The data line uses open-drain signalling: `sda_o` is held low, and `sda_oe` pulls the line down. A strap input picks the low address bit. A three-level strap input gives the default spread-spectrum setting, and software can override it. The bank drives output enables, spread selection, amplitude and slew controls in parallel.

Top module: `smb_clkgen_cfg`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal {ADDR_BASE[6:1], addr_sel} (default base 7'h68). Any other address gets no acknowledge. After a mismatch the target acknowledges nothing and stores nothing until the next START.
- R2: In a write, the target acknowledges the address (R/W bit 0), the index byte N and the count byte X. Data byte k (k < X) is acknowledged and stored at index N+k, with the index wrapping modulo 256.
- R3: A data byte that arrives after X bytes have already been stored is not acknowledged and is discarded. Any byte after it is also not acknowledged.
- R4: In a read (write address, index N, repeated START, address with R/W bit 1), the target first sends the count byte {3'b000, index7[4:0]}. It then sends bytes from index N, N+1 and so on while the host acknowledges. After the host's NACK it releases the data line.
- R5: Index 7 bits 4:0 hold the read byte count and reset to 8. Bits 7:5 read 0.
- R6: The `ss_mode` output uses 00 for off, 01 for -0.25% and 11 for -0.5%. When index 1 bit 5 is 0, the strap sets it: ss_strap 00 (low) gives 00, 01 (mid) gives 01, and 10 or 11 (high) gives 11. When index 1 bit 5 is 1, index 1 bits 4:3 set it and the strap has no effect.
- R7: Index 1 bits 7:6 read back the strap in the same encoding as R6. Writes to these bits are ignored.
- R8: Index 3 reads 0x00, index 4 reads 0xFF, index 5 reads REV_ID (0x01) and index 6 reads DEV_ID (0x02). Writes to these indices are ignored.
- R9: `out_en` is index 0 bits 2:1 (reset 11). `amp_sel` is index 1 bits 1:0 (reset 10). `slew_sel` is index 2 bits 2:1 (reset 11). Index 1 bit 5 resets to 0 and bits 4:3 reset to 00. All other bits of indices 0, 1 and 2 read 0.
- R10: A write to an index of 8 or above is acknowledged and has no effect. A read of such an index returns 0x00.
- R11: A START or STOP inside a transfer ends it. A START restarts address reception. Bytes already stored stay stored, and a partly received byte is dropped.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_o | output | 1 | Data value driven when enabled (always 0) |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| addr_sel | input | 1 | Strap for the low address bit |
| ss_strap | input | 2 | Spread strap: 00 low, 01 mid, 10 or 11 high |
| out_en | output | 2 | Clock output enables |
| ss_mode | output | 2 | Effective spread selection |
| amp_sel | output | 2 | Output amplitude selection |
| slew_sel | output | 2 | Output slew selection |

## Verification
Two events can fall in the same cycle: a START or STOP arriving while a data byte is still being shifted in, and the commit of the byte just finished. The bench ends a write after a complete byte with a STOP, and checks that this byte was kept. It then cuts a later byte off after four bits with a repeated START, and checks by reading back that the partial byte never reached the bank. A second overlap is the strap input changing while the software override is on. The bench moves the strap during that window and checks that `ss_mode` stays fixed while the bits 7:6 readback follows the strap.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] IX_ENABLES = 8'd0;
    localparam logic [7:0] IX_SPREAD  = 8'd1;
    localparam logic [7:0] IX_SLEW    = 8'd2;
    localparam logic [7:0] IX_BLANK   = 8'd3;
    localparam logic [7:0] IX_ONES    = 8'd4;
    localparam logic [7:0] IX_REV     = 8'd5;
    localparam logic [7:0] IX_DEV     = 8'd6;
    localparam logic [7:0] IX_COUNT   = 8'd7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_IGNORE
    } link_state_e;

    typedef enum logic [1:0] {
        PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA
    } rx_phase_e;

    typedef struct packed {
        link_state_e        st;
        rx_phase_e          ph;
        logic [3:0]         bits;
        logic [BYTE_W-1:0]  shift;
        logic [BYTE_W-1:0]  ptr;
        logic [BYTE_W-1:0]  remain;
        logic               is_read;
        logic               host_ack;
        logic               pull;
        logic               wr;
        logic [BYTE_W-1:0]  wr_ix;
        logic [BYTE_W-1:0]  wr_val;
    } link_t;

    typedef struct packed {
        logic [1:0] enables;
        logic       sw_spread;
        logic [1:0] sw_ss;
        logic [1:0] amp;
        logic [1:0] slew;
        logic [4:0] rd_count;
    } bank_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_ff_q, scl_ff_d;
    logic [TOP:0] sda_ff_q, sda_ff_d;
    logic         scl_prev_q, sda_prev_q;

    always_comb begin
        scl_ff_d = {scl_ff_q[TOP-1:0], scl_i};
        sda_ff_d = {sda_ff_q[TOP-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff_q   <= '1;
            sda_ff_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_ff_q   <= scl_ff_d;
            sda_ff_q   <= sda_ff_d;
            scl_prev_q <= scl_ff_q[TOP];
            sda_prev_q <= sda_ff_q[TOP];
        end
    end

    assign scl_s     = scl_ff_q[TOP];
    assign sda_s     = sda_ff_q[TOP];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & ~sda_s & sda_prev_q;
    assign stop_det  = scl_s & scl_prev_q & sda_s & ~sda_prev_q;

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
    import smb_cfg_pkg::*;
#(
    parameter logic [7:0] REV_ID   = 8'h01,
    parameter logic [7:0] DEV_ID   = 8'h02,
    parameter logic [4:0] BC_RESET = 5'd8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_ix,
    input  logic [7:0] wr_val,
    input  logic [7:0] rd_ix,
    input  logic [1:0] ss_strap,
    output logic [7:0] rd_val,
    output logic [4:0] rd_count,
    output logic [1:0] out_en,
    output logic [1:0] ss_mode,
    output logic [1:0] amp_sel,
    output logic [1:0] slew_sel
);
    bank_t bank_q, bank_d;
    logic [1:0] strap_code;
    logic       unused_wr_hi;

    assign unused_wr_hi = ^wr_val[7:6];

    always_comb begin
        case (ss_strap)
            2'b00:   strap_code = 2'b00;
            2'b01:   strap_code = 2'b01;
            default: strap_code = 2'b11;
        endcase
    end

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (wr_ix)
                IX_ENABLES: bank_d.enables = wr_val[2:1];
                IX_SPREAD: begin
                    bank_d.sw_spread = wr_val[5];
                    bank_d.sw_ss     = wr_val[4:3];
                    bank_d.amp       = wr_val[1:0];
                end
                IX_SLEW:    bank_d.slew     = wr_val[2:1];
                IX_COUNT:   bank_d.rd_count = wr_val[4:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.enables   <= 2'b11;
            bank_q.sw_spread <= 1'b0;
            bank_q.sw_ss     <= 2'b00;
            bank_q.amp       <= 2'b10;
            bank_q.slew      <= 2'b11;
            bank_q.rd_count  <= BC_RESET;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        case (rd_ix)
            IX_ENABLES: rd_val = {5'b0, bank_q.enables, 1'b0};
            IX_SPREAD:  rd_val = {strap_code, bank_q.sw_spread, bank_q.sw_ss, 1'b0, bank_q.amp};
            IX_SLEW:    rd_val = {5'b0, bank_q.slew, 1'b0};
            IX_BLANK:   rd_val = 8'h00;
            IX_ONES:    rd_val = 8'hFF;
            IX_REV:     rd_val = REV_ID;
            IX_DEV:     rd_val = DEV_ID;
            IX_COUNT:   rd_val = {3'b0, bank_q.rd_count};
            default:    rd_val = 8'h00;
        endcase
    end

    assign rd_count = bank_q.rd_count;
    assign out_en   = bank_q.enables;
    assign amp_sel  = bank_q.amp;
    assign slew_sel = bank_q.slew;
    assign ss_mode  = bank_q.sw_spread ? bank_q.sw_ss : strap_code;

    // Enables move only on the cycle after a write strobe aimed at index 0.
    assert_enables_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_en) |-> ($past(wr_en) && $past(wr_ix) == IX_ENABLES));

    // The read count moves only after a write aimed at index 7.
    assert_count_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_count) |-> ($past(wr_en) && $past(wr_ix) == IX_COUNT));

endmodule

// File: rtl/smb_clkgen_cfg.sv
module smb_clkgen_cfg
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE   = 7'h68,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] REV_ID      = 8'h01,
    parameter logic [7:0] DEV_ID      = 8'h02,
    parameter logic [4:0] BC_RESET    = 5'd8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic [1:0] ss_strap,
    output logic [1:0] out_en,
    output logic [1:0] ss_mode,
    output logic [1:0] amp_sel,
    output logic [1:0] slew_sel
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
    localparam logic [3:0] FULL     = 4'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_val;
    logic [4:0] rd_count;
    logic [6:0] own_addr;
    logic [7:0] count_byte;
    link_t q, d;

    assign own_addr   = {ADDR_BASE[6:1], addr_sel};
    assign count_byte = {3'b0, rd_count};

    smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_cfg_bank #(.REV_ID(REV_ID), .DEV_ID(DEV_ID), .BC_RESET(BC_RESET)) i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(q.wr), .wr_ix(q.wr_ix), .wr_val(q.wr_val),
        .rd_ix(q.ptr), .ss_strap(ss_strap), .rd_val(rd_val), .rd_count(rd_count),
        .out_en(out_en), .ss_mode(ss_mode), .amp_sel(amp_sel), .slew_sel(slew_sel)
    );

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (start_det) begin
            d.st   = ST_RX;
            d.ph   = PH_ADDR;
            d.bits = '0;
            d.pull = 1'b0;
        end else if (stop_det) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.bits < FULL) begin
                        d.shift = {q.shift[6:0], sda_s};
                        d.bits  = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == FULL) begin
                        d.bits = '0;
                        d.st   = ST_RX_ACK;
                        d.pull = 1'b1;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.shift[7:1] != own_addr) begin
                                    d.st   = ST_IGNORE;
                                    d.pull = 1'b0;
                                end else begin
                                    d.is_read = q.shift[0];
                                end
                            end
                            PH_INDEX: d.ptr    = q.shift;
                            PH_COUNT: d.remain = q.shift;
                            default: begin
                                if (q.remain == '0) begin
                                    d.st   = ST_IGNORE;
                                    d.pull = 1'b0;
                                end else begin
                                    d.wr     = 1'b1;
                                    d.wr_ix  = q.ptr;
                                    d.wr_val = q.shift;
                                    d.ptr    = q.ptr + 8'd1;
                                    d.remain = q.remain - 8'd1;
                                end
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.bits = '0;
                        if (q.ph == PH_ADDR && q.is_read) begin
                            d.st    = ST_TX;
                            d.shift = count_byte;
                            d.pull  = ~count_byte[7];
                        end else begin
                            d.st   = ST_RX;
                            d.pull = 1'b0;
                            case (q.ph)
                                PH_ADDR:  d.ph = PH_INDEX;
                                PH_INDEX: d.ph = PH_COUNT;
                                default:  d.ph = PH_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bits == LAST_BIT) begin
                            d.st   = ST_TX_ACK;
                            d.pull = 1'b0;
                            d.bits = '0;
                        end else begin
                            d.bits  = q.bits + 4'd1;
                            d.shift = {q.shift[6:0], 1'b0};
                            d.pull  = ~q.shift[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.host_ack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.host_ack) begin
                            d.st    = ST_TX;
                            d.shift = rd_val;
                            d.pull  = ~rd_val[7];
                            d.ptr   = q.ptr + 8'd1;
                            d.bits  = '0;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ph: PH_ADDR, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.pull;
    assign sda_o  = 1'b0;

    // The data line is only pulled or released while SCL is low.
    assert_pull_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.pull) |-> !scl_s);

    // A START always lands the engine at the start of address reception.
    assert_start_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.st == ST_RX && q.ph == PH_ADDR && q.bits == 4'd0));

    // Each stored byte advances the index by exactly one.
    assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> q.ptr == q.wr_ix + 8'd1);

    // The store strobe is a single-cycle pulse.
    assert_store_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);

    // A NACKed address never leads to a pulled line.
    assert_mismatch_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RX && q.ph == PH_ADDR && scl_fall && q.bits == FULL
         && q.shift[7:1] != own_addr) |=> !q.pull);

endmodule

// File: tb/test_smb_clkgen_cfg.sv
module test_smb_clkgen_cfg;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 12;
    localparam int WATCHDOG   = 190000;
    localparam logic [6:0] ADDR_BASE = 7'h68;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic addr_sel = 1'b0;
    logic [1:0] ss_strap = 2'b00;
    logic sda_o, sda_oe;
    logic [1:0] out_en, ss_mode, amp_sel, slew_sel;
    wire  sda_line = host_sda & ~sda_oe;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int edge_viol = 0;
    logic prev_oe = 1'b0;

    logic [1:0] m_oe = 2'b11, m_sw_ss = 2'b00, m_amp = 2'b10, m_slew = 2'b11;
    logic       m_sw_en = 1'b0;
    logic [4:0] m_bc = 5'd8;
    logic [7:0] wbuf [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_clkgen_cfg i_smb_clkgen_cfg (
        .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe(sda_oe), .addr_sel(addr_sel), .ss_strap(ss_strap),
        .out_en(out_en), .ss_mode(ss_mode), .amp_sel(amp_sel), .slew_sel(slew_sel)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        prev_oe <= sda_oe;
        if (rst_n && sda_oe != prev_oe && host_scl) edge_viol <= edge_viol + 1;
        if (cycles > WATCHDOG) begin
            n_checks = n_checks + 1;
            n_fails  = n_fails + 1;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] strap_code();
        case (ss_strap)
            2'b00:   return 2'b00;
            2'b01:   return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [1:0] exp_ss();
        return m_sw_en ? m_sw_ss : strap_code();
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] ix);
        case (ix)
            8'd0:    return {5'b0, m_oe, 1'b0};
            8'd1:    return {strap_code(), m_sw_en, m_sw_ss, 1'b0, m_amp};
            8'd2:    return {5'b0, m_slew, 1'b0};
            8'd3:    return 8'h00;
            8'd4:    return 8'hFF;
            8'd5:    return 8'h01;
            8'd6:    return 8'h02;
            8'd7:    return {3'b0, m_bc};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] ix);
        if (ix == 8'd7) return "R5";
        if (ix == 8'd1) return "R7";
        if (ix >= 8'd3 && ix <= 8'd6) return "R8";
        if (ix >= 8'd8) return "R10";
        return "R9";
    endfunction

    task automatic model_write(input logic [7:0] ix, input logic [7:0] v);
        case (ix)
            8'd0: m_oe = v[2:1];
            8'd1: begin m_sw_en = v[5]; m_sw_ss = v[4:3]; m_amp = v[1:0]; end
            8'd2: m_slew = v[2:1];
            8'd7: m_bc = v[4:0];
            default: ;
        endcase
    endtask

    function automatic logic [6:0] own_addr();
        return {ADDR_BASE[6:1], addr_sel};
    endfunction

    task automatic bus_start();
        host_sda = 1'b1; wait_clk(HALF/2);
        host_scl = 1'b1; wait_clk(HALF);
        host_sda = 1'b0; wait_clk(HALF);
        host_scl = 1'b0; wait_clk(HALF/2);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wait_clk(HALF/2);
        host_scl = 1'b1; wait_clk(HALF);
        host_sda = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            host_sda = b[7-i]; wait_clk(HALF/2);
            host_scl = 1'b1;   wait_clk(HALF);
            host_scl = 1'b0;   wait_clk(HALF/2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        host_sda = 1'b1; wait_clk(HALF/2);
        host_scl = 1'b1; wait_clk(HALF/2);
        ack = !sda_line; wait_clk(HALF/2);
        host_scl = 1'b0; wait_clk(HALF/2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        host_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_clk(HALF/2);
            host_scl = 1'b1; wait_clk(HALF/2);
            b[7-i] = sda_line; wait_clk(HALF/2);
            host_scl = 1'b0;
        end
        wait_clk(HALF/2);
        host_sda = give_ack ? 1'b0 : 1'b1; wait_clk(HALF/2);
        host_scl = 1'b1; wait_clk(HALF);
        host_scl = 1'b0; wait_clk(HALF/2);
        host_sda = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] ix, input logic [7:0] cnt, input int nb);
        bit ack;
        bus_start();
        send_byte({own_addr(), 1'b0}, ack);
        check(ack, "R1", "write address ack", 32'(ack), 1);
        send_byte(ix, ack);
        check(ack, "R2", "index ack", 32'(ack), 1);
        send_byte(cnt, ack);
        check(ack, "R2", "count ack", 32'(ack), 1);
        for (int i = 0; i < nb; i++) begin
            send_byte(wbuf[i], ack);
            if (i < int'(cnt)) begin
                check(ack, "R2", "data ack", 32'(ack), 1);
                model_write(8'(ix + 8'(i)), wbuf[i]);
            end else begin
                check(!ack, "R3", "extra byte nack", 32'(ack), 0);
            end
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] ix, input int nb);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({own_addr(), 1'b0}, ack);
        check(ack, "R4", "read setup address ack", 32'(ack), 1);
        send_byte(ix, ack);
        check(ack, "R4", "read index ack", 32'(ack), 1);
        bus_start();
        send_byte({own_addr(), 1'b1}, ack);
        check(ack, "R4", "read address ack", 32'(ack), 1);
        recv_byte(1'b1, b);
        check(b == {3'b0, m_bc}, "R5", "count byte", 32'(b), 32'({3'b0, m_bc}));
        for (int i = 0; i < nb; i++) begin
            logic [7:0] e;
            logic [7:0] at;
            at = 8'(ix + 8'(i));
            e  = exp_byte(at);
            recv_byte(i < nb - 1, b);
            check(b == e, req_of(at), "read byte", 32'(b), 32'(e));
        end
        wait_clk(2);
        check(!sda_oe, "R4", "line released after nack", 32'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic check_outputs(input string req);
        wait_clk(2);
        check(out_en == m_oe, req, "out_en", 32'(out_en), 32'(m_oe));
        check(ss_mode == exp_ss(), "R6", "ss_mode", 32'(ss_mode), 32'(exp_ss()));
        check(amp_sel == m_amp, req, "amp_sel", 32'(amp_sel), 32'(m_amp));
        check(slew_sel == m_slew, req, "slew_sel", 32'(slew_sel), 32'(m_slew));
    endtask

    initial begin
        bit ack;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R9 / R6: reset values
        check_outputs("R9");

        // R5, R7, R8, R9: full readback after reset
        do_read(8'd0, 8);

        // R2: disable both outputs through index 0
        wbuf[0] = 8'h00;
        do_write(8'd0, 8'd1, 1);
        check_outputs("R2");

        // R3: second byte past the count is discarded
        wbuf[0] = 8'h00; wbuf[1] = 8'hFF;
        do_write(8'd2, 8'd1, 2);
        check_outputs("R3");
        do_read(8'd2, 2);

        // R10: index beyond the bank
        wbuf[0] = 8'h55; wbuf[1] = 8'hAA;
        do_write(8'd9, 8'd2, 2);
        check_outputs("R10");
        do_read(8'd8, 3);

        // R8: writes to fixed bytes are ignored
        wbuf[0] = 8'h5A; wbuf[1] = 8'h00; wbuf[2] = 8'h00; wbuf[3] = 8'h00;
        do_write(8'd3, 8'd4, 4);
        do_read(8'd3, 4);

        // R6: strap drives spread while override is off
        for (int s = 0; s < 4; s++) begin
            ss_strap = 2'(s);
            check_outputs("R6");
        end
        wbuf[0] = 8'h38 | 8'h02;
        do_write(8'd1, 8'd1, 1);
        for (int s = 0; s < 4; s++) begin
            ss_strap = 2'(s);
            check_outputs("R6");
        end
        // R7: readback follows strap while override is on
        ss_strap = 2'b01;
        do_read(8'd1, 1);
        wbuf[0] = 8'hE9;
        do_write(8'd1, 8'd1, 1);
        check_outputs("R6");
        do_read(8'd1, 1);

        // R1: foreign address ignored until next START
        bus_start();
        send_byte({own_addr() ^ 7'h01, 1'b0}, ack);
        check(!ack, "R1", "foreign address nack", 32'(ack), 0);
        send_byte(8'h00, ack);
        check(!ack, "R1", "ignored byte nack", 32'(ack), 0);
        send_byte(8'h01, ack);
        check(!ack, "R1", "ignored byte nack", 32'(ack), 0);
        send_byte(8'h00, ack);
        check(!ack, "R1", "ignored byte nack", 32'(ack), 0);
        bus_stop();
        check_outputs("R1");
        addr_sel = 1'b1;
        wbuf[0] = 8'h02;
        do_write(8'd0, 8'd1, 1);
        check_outputs("R1");

        // R11: STOP after a whole byte keeps it
        bus_start();
        send_byte({own_addr(), 1'b0}, ack);
        send_byte(8'd0, ack);
        send_byte(8'd3, ack);
        send_byte(8'h04, ack);
        model_write(8'd0, 8'h04);
        bus_stop();
        check_outputs("R11");
        // R11: START inside a byte drops it
        bus_start();
        send_byte({own_addr(), 1'b0}, ack);
        send_byte(8'd2, ack);
        send_byte(8'd1, ack);
        send_bits(8'h00, 4);
        bus_start();
        bus_stop();
        check_outputs("R11");
        do_read(8'd0, 3);

        // Random mix
        for (int t = 0; t < 22; t++) begin
            logic [7:0] ix;
            int cnt, nb;
            ix  = 8'($urandom_range(0, 9));
            cnt = int'($urandom_range(1, 4));
            nb  = ($urandom_range(0, 3) == 0) ? cnt + 1 : cnt;
            for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
            ss_strap = 2'($urandom_range(0, 3));
            do_write(ix, 8'(cnt), nb);
            check_outputs("R2");
            do_read(ix, cnt + 1);
        end

        // R12: line changes only while SCL low
        check(edge_viol == 0, "R12", "pull changes while SCL high", 32'(edge_viol), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule